// File: doc/BRIEF.md
# Shared-Period Multi-Channel PWM Generator

This block drives a bank of output pins from a single free-running 16-bit counter. One compare value sets the period that all channels share and wraps the counter. Each of a small number of channel slots holds a pulse-width compare for one pin. Software-side logic, or another block, sends configuration requests over a valid/ready port. Each request names a pin, a period and a pulse width. The block checks the period against the one already running, finds or claims a slot, applies the setting, and reports one status code.

A running channel produces its waveform by toggling. The pin starts low, toggles high on its own compare match, and toggles low again when the period wraps. A pulse width of zero, or a pulse width equal to the period, is a static level. It needs no slot and releases any slot the pin held. When the last running channel goes static, the counter stops. Periods wider than the counter are shifted right, together with their pulse widths, until they fit. The counter advances once every 2^`prescale` clocks.

The request port accepts one request at a time. `req_ready` is high only while the block is idle. After a request is accepted, `req_ready` drops for exactly one cycle, and during that cycle `rsp_valid` is high with the status. A requester holding `req_valid` high simply waits for `req_ready`, and the request fields must stay stable until it is accepted.

Top module: `pwm_shared_period`

## Requirements
- R1: `req_ready` is high when idle. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. In the following cycle `rsp_valid` is high for exactly one cycle and `req_ready` is low.
- R2: `rsp_status` is encoded as follows: 0 means accepted, 1 means period conflict, 2 means no free channel. A rejected request changes no pin and no slot.
- R3: A request with a non-static pulse is rejected with status 1 when some slot mapped to a different pin is running and the requested period differs from the period currently in force.
- R4: A non-static request uses the lowest-numbered slot already mapped to its pin. Otherwise it claims the highest-numbered slot that is not running. If every one of the NUM_CH slots (default 3) is running, it returns status 2.
- R5: A pulse of 0 drives the pin low and holds it there. A pulse equal to the period drives the pin high and holds it there. Both return status 0 even when all slots are busy or the period differs, and both stop the pin's slot from running.
- R6: A running channel with scaled period P and scaled pulse W is low for W counter steps and high for P-W counter steps, repeating every P steps.
- R7: For a period wider than 16 bits, the period and the pulse are both shifted right by the smallest amount that makes the period fit in 16 bits.
- R8: The counter advances once every 2^`prescale` clock cycles.
- R9: An accepted non-static request resets the counter to zero and drives every running pin low. This keeps all channels phase-aligned, so each one keeps its R6 high time per period. The reconfigured slot cannot toggle until the response cycle is over.
- R10: When no slot is running, the counter is stopped. Every pin then keeps its static level, and any period is accepted for the next request.
- R11: A synchronous active-low reset drives every pin low, releases every slot and stops the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prescale | input | 4 | Counter advances every 2^prescale clocks |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_pin | input | 3 | Target pin index |
| req_period | input | 32 | Period in counter ticks |
| req_pulse | input | 32 | Pulse width in counter ticks |
| rsp_valid | output | 1 | Status valid (one cycle) |
| rsp_status | output | 2 | 0 accepted, 1 period conflict, 2 no free channel |
| pwm_out | output | 8 | Pin levels |

## Verification
The assertions assume that the pulse never exceeds the period. They also assume that a non-static pulse still scales to at least one tick, and that the request fields are stable while `req_valid` waits for `req_ready`. The stimulus draws each pulse from zero up to its period, uses periods of at least four ticks, and changes request fields only between handshakes. Random traffic is limited to two periods and all eight pins, so that conflicts, slot exhaustion, slot reuse and static releases all occur. Directed cases cover scaling of a wide period and a non-zero prescale.

// File: rtl/pwm_share_pkg.sv
package pwm_share_pkg;
  typedef enum logic [1:0] {
    ST_OK       = 2'd0,
    ST_CONFLICT = 2'd1,
    ST_NOFREE   = 2'd2
  } status_e;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_RESP = 1'b1
  } state_e;
endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] prescale,
  output logic             tick
);
  localparam int DIV_W = (1 << PRE_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < DIV_W; i++) mask[i] = (i < int'(prescale));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  assign tick = ((div_q & mask) == mask);

  // R8: with a divide of two or more, ticks never come back to back
  a_r8_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && prescale != '0) |=> (!tick || prescale != $past(prescale)));
endmodule

// File: rtl/pwm_period_counter.sv
module pwm_period_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             clear,
  input  logic [CNT_W-1:0] period_m1,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  always_ff @(posedge clk) begin
    if (!rst_n)                        cnt <= '0;
    else if (clear)                    cnt <= '0;
    else if (step && cnt == period_m1) cnt <= '0;
    else if (step)                     cnt <= cnt + 1'b1;
  end

  assign wrap = step && (cnt == period_m1);

  // R6: a stepping counter never runs past the shared period
  a_r6_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (cnt <= period_m1));
endmodule

// File: rtl/pwm_slot_alloc.sv
module pwm_slot_alloc
  import pwm_share_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int PIN_W  = 3,
  parameter int PER_W  = 32,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0]            mapped,
  input  logic [NUM_CH-1:0]            active,
  input  logic [NUM_CH-1:0][PIN_W-1:0] slot_pin,
  input  logic [PER_W-1:0]             cur_period,
  input  logic [PIN_W-1:0]             req_pin,
  input  logic [PER_W-1:0]             req_period,
  input  logic                         req_static,
  output status_e                      status,
  output logic [IDX_W-1:0]             slot_idx,
  output logic                         hit
);
  logic             conflict;
  logic             free_found;
  logic [IDX_W-1:0] hit_idx;
  logic [IDX_W-1:0] free_idx;

  always_comb begin
    conflict   = 1'b0;
    hit        = 1'b0;
    hit_idx    = '0;
    free_found = 1'b0;
    free_idx   = '0;
    // R3: another pin running at a different period blocks the request
    for (int i = 0; i < NUM_CH; i++) begin
      if (active[i] && slot_pin[i] != req_pin && req_period != cur_period)
        conflict = 1'b1;
    end
    // R4: lowest mapped slot wins, scanned downward so the last write is lowest
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (mapped[i] && slot_pin[i] == req_pin) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
    // R4: highest idle slot, scanned upward so the last write is highest
    for (int i = 0; i < NUM_CH; i++) begin
      if (!active[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
    if (req_static)                 status = ST_OK;
    else if (conflict)              status = ST_CONFLICT;
    else if (hit || free_found)     status = ST_OK;
    else                            status = ST_NOFREE;
    slot_idx = hit ? hit_idx : free_idx;
  end
endmodule

// File: rtl/pwm_shared_period.sv
module pwm_shared_period
  import pwm_share_pkg::*;
#(
  parameter int NUM_CH   = 3,
  parameter int NUM_PINS = 8,
  parameter int PER_W    = 32,
  parameter int CNT_W    = 16,
  parameter int PRE_W    = 4,
  localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PRE_W-1:0]    prescale,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [PIN_W-1:0]    req_pin,
  input  logic [PER_W-1:0]    req_period,
  input  logic [PER_W-1:0]    req_pulse,
  output logic                rsp_valid,
  output logic [1:0]          rsp_status,
  output logic [NUM_PINS-1:0] pwm_out
);
  localparam int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int SH_MAX = (PER_W > CNT_W) ? PER_W - CNT_W : 0;

  state_e                      state_q;
  status_e                     status_q;
  logic [NUM_CH-1:0]           active_q, mapped_q, en_q;
  logic [NUM_CH-1:0][PIN_W-1:0] slot_pin_q;
  logic [NUM_CH-1:0][CNT_W-1:0] wcmp_q;
  logic [CNT_W-1:0]            pcmp_q;
  logic [PER_W-1:0]            cur_period_q;
  logic                        run_q, hold_q;
  logic [NUM_PINS-1:0]         pin_q;

  // R7: smallest right shift that fits the period into the counter
  function automatic int scale_of(input logic [PER_W-1:0] p);
    int s;
    s = SH_MAX;
    for (int k = SH_MAX; k >= 0; k--)
      if (((p >> k) >> CNT_W) == '0) s = k;
    return s;
  endfunction

  int               sh;
  logic [CNT_W-1:0] p_s, w_s;
  always_comb begin
    sh  = scale_of(req_period);
    p_s = CNT_W'(req_period >> sh);
    w_s = CNT_W'(req_pulse >> sh);
  end

  logic is_static;
  assign is_static = (req_pulse == '0) || (req_pulse == req_period);

  status_e          alloc_status;
  logic [IDX_W-1:0] alloc_idx;
  logic             alloc_hit;

  pwm_slot_alloc #(.NUM_CH(NUM_CH), .PIN_W(PIN_W), .PER_W(PER_W)) u_alloc (
    .mapped     (mapped_q),
    .active     (active_q),
    .slot_pin   (slot_pin_q),
    .cur_period (cur_period_q),
    .req_pin    (req_pin),
    .req_period (req_period),
    .req_static (is_static),
    .status     (alloc_status),
    .slot_idx   (alloc_idx),
    .hit        (alloc_hit)
  );

  logic acc, ok_pwm, ok_static, others_active, do_clear;
  logic [NUM_CH-1:0] self_mask;
  assign acc           = req_valid && req_ready;
  assign ok_pwm        = acc && alloc_status == ST_OK && !is_static;
  assign ok_static     = acc && alloc_status == ST_OK && is_static;
  assign self_mask     = alloc_hit ? (NUM_CH'(1) << alloc_idx) : '0;
  assign others_active = |(active_q & ~self_mask);
  assign do_clear      = ok_pwm || (ok_static && !others_active);

  logic             tick, step, wrap;
  logic [CNT_W-1:0] cnt;

  pwm_tick_gen #(.PRE_W(PRE_W)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .prescale (prescale),
    .tick     (tick)
  );

  assign step = run_q && tick && !hold_q;

  pwm_period_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .clear     (do_clear),
    .period_m1 (pcmp_q),
    .cnt       (cnt),
    .wrap      (wrap)
  );

  logic [NUM_CH-1:0] ch_hit;
  for (genvar g = 0; g < NUM_CH; g++) begin : g_match
    assign ch_hit[g] = step && (cnt == wcmp_q[g]);
  end

  // R6: each running slot toggles its pin on its own match and on the wrap
  logic [NUM_PINS-1:0] tog;
  always_comb begin
    tog = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (active_q[i] && en_q[i] && (ch_hit[i] ^ wrap)) tog[slot_pin_q[i]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= S_IDLE;
      status_q     <= ST_OK;
      active_q     <= '0;
      mapped_q     <= '0;
      en_q         <= '1;
      slot_pin_q   <= '0;
      wcmp_q       <= '0;
      pcmp_q       <= '0;
      cur_period_q <= '0;
      run_q        <= 1'b0;
      hold_q       <= 1'b0;
      pin_q        <= '0;
    end else begin
      pin_q <= pin_q ^ tog;
      if (state_q == S_RESP) begin
        state_q <= S_IDLE;
        en_q    <= '1;
        hold_q  <= 1'b0;
      end else if (acc) begin
        state_q  <= S_RESP;
        status_q <= alloc_status;
      end
      if (ok_static) begin
        if (alloc_hit) active_q[alloc_idx] <= 1'b0;
        pin_q[req_pin] <= (req_pulse != '0);
        if (!others_active) run_q <= 1'b0;
      end
      if (ok_pwm) begin
        // R9: restart every running pin low so all phases line up again
        for (int i = 0; i < NUM_CH; i++)
          if (active_q[i]) pin_q[slot_pin_q[i]] <= 1'b0;
        pin_q[req_pin]        <= 1'b0;
        mapped_q[alloc_idx]   <= 1'b1;
        active_q[alloc_idx]   <= 1'b1;
        slot_pin_q[alloc_idx] <= req_pin;
        wcmp_q[alloc_idx]     <= w_s - 1'b1;
        en_q[alloc_idx]       <= 1'b0;
        pcmp_q                <= p_s - 1'b1;
        cur_period_q          <= req_period;
        run_q                 <= 1'b1;
        hold_q                <= 1'b1;
      end
    end
  end

  assign req_ready  = (state_q == S_IDLE);
  assign rsp_valid  = (state_q == S_RESP);
  assign rsp_status = status_q;
  assign pwm_out    = pin_q;

  logic [NUM_CH-1:0] pin_match;
  always_comb begin
    for (int i = 0; i < NUM_CH; i++) pin_match[i] = mapped_q[i] && slot_pin_q[i] == req_pin;
  end

  a_r1_rsp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
  a_r1_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r1_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  a_r4_unique_map: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pin_match) <= 1);
  a_r5_static_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_pulse == '0) |=> (rsp_status == 2'd0));
  a_r10_stop_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(|active_q) |-> !run_q);
  a_r9_new_slot_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && hold_q) |-> !step);
endmodule

// File: tb/pwm_shared_period_bench.sv
`timescale 1ns/1ps
module pwm_shared_period_bench;
  localparam int NCH = 3;
  localparam int NP  = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  prescale = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_pin = '0;
  logic [31:0] req_period = '0;
  logic [31:0] req_pulse = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_status;
  logic [7:0]  pwm_out;

  always #2.5 clk = ~clk;

  pwm_shared_period u_pwm_shared_period (
    .clk(clk), .rst_n(rst_n), .prescale(prescale),
    .req_valid(req_valid), .req_ready(req_ready), .req_pin(req_pin),
    .req_period(req_period), .req_pulse(req_pulse),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .pwm_out(pwm_out)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model of the slot table
  bit      m_act [NCH];
  bit      m_map [NCH];
  int      m_pin [NCH];
  longint  m_pul [NCH];
  longint  m_per = 0;
  bit      m_lvl [NP];
  int      hi [NP];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int shift_for(input longint per);
    int s = 0;
    while ((per >> s) > 65535) s++;
    return s;
  endfunction

  // R2 R3 R4 R5: predicted status and model update
  function automatic int model_req(input int pin, input longint per, input longint pul);
    bit st_c = (pul == 0) || (pul == per);
    int hit = -1, fr = -1, idx;
    if (!st_c)
      for (int i = 0; i < NCH; i++)
        if (m_act[i] && m_pin[i] != pin && per != m_per) return 1;
    for (int i = NCH - 1; i >= 0; i--) if (m_map[i] && m_pin[i] == pin) hit = i;
    for (int i = 0; i < NCH; i++) if (!m_act[i]) fr = i;
    if (st_c) begin
      if (hit >= 0) m_act[hit] = 1'b0;
      m_lvl[pin] = (pul != 0);
      return 0;
    end
    if (hit < 0 && fr < 0) return 2;
    idx = (hit >= 0) ? hit : fr;
    m_act[idx] = 1'b1; m_map[idx] = 1'b1; m_pin[idx] = pin; m_pul[idx] = pul;
    m_per = per;
    return 0;
  endfunction

  task automatic send(input int pin, input longint per, input longint pul);
    int exp_st;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_pin = 3'(pin); req_period = 32'(per); req_pulse = 32'(pul);
    @(negedge clk);
    req_valid = 1'b0;
    exp_st = model_req(pin, per, pul);
    chk(rsp_valid === 1'b1, "R1 rsp_valid after accept", rsp_valid, 1);
    chk(req_ready === 1'b0, "R1 ready low in response cycle", req_ready, 0);
    chk(rsp_status == 2'(exp_st), "R2 R3 R4 R5 status", rsp_status, exp_st);
    @(negedge clk);
    chk(rsp_valid === 1'b0 && req_ready === 1'b1, "R1 single response", rsp_valid, 0);
  endtask

  // R6 R9 R10: high time of every pin over one or more whole periods
  task automatic check_all(input int mult, input string tag);
    bit any = 1'b0;
    int sh, ps, win;
    for (int i = 0; i < NCH; i++) if (m_act[i]) any = 1'b1;
    sh  = shift_for(m_per);
    ps  = int'(m_per >> sh);
    win = any ? ps * mult : 16;
    for (int p = 0; p < NP; p++) hi[p] = 0;
    repeat (win) begin
      for (int p = 0; p < NP; p++) hi[p] += int'(pwm_out[p]);
      @(negedge clk);
    end
    for (int p = 0; p < NP; p++) begin
      int e = m_lvl[p] ? win : 0;
      for (int i = 0; i < NCH; i++)
        if (m_act[i] && m_pin[i] == p) e = (ps - int'(m_pul[i] >> sh)) * mult;
      chk(hi[p] == e, tag, hi[p], e);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NCH; i++) begin m_act[i] = 0; m_map[i] = 0; m_pin[i] = 0; m_pul[i] = 0; end
    for (int p = 0; p < NP; p++) m_lvl[p] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    chk(pwm_out == 8'h00, "R11 pins low after reset", pwm_out, 0);
    chk(req_ready === 1'b1 && rsp_valid === 1'b0, "R11 idle handshake after reset", req_ready, 1);

    // R6: one channel
    send(3, 20, 5);  check_all(1, "R6 single channel high time");
    // R3: other pin at a different period rejected
    send(5, 30, 7);  check_all(1, "R3 conflict leaves pins unchanged");
    // R5: static levels never rejected
    send(5, 30, 0);  send(6, 30, 30); check_all(1, "R5 static levels");
    // R4: fill slots, exhaustion, reuse
    send(1, 20, 8);  send(2, 20, 15); check_all(1, "R9 three aligned channels");
    send(4, 20, 9);  check_all(1, "R4 no free channel leaves pins unchanged");
    send(3, 20, 12); check_all(1, "R4 reuse own slot");
    send(2, 20, 20); send(4, 20, 9); check_all(1, "R4 freed slot reclaimed");
    // R10: all static, counter stops, any period accepted
    send(1, 20, 0); send(3, 20, 0); send(4, 20, 20);
    check_all(1, "R10 static after stop");
    send(7, 36, 11); check_all(1, "R10 new period after stop");
    // R8: prescale of one
    prescale = 4'd1;
    check_all(2, "R8 prescale doubles step time");
    prescale = 4'd0;
    // R7: wide period scaled
    send(7, 36, 0);
    send(0, 32'h0002_0000, 32'h0000_8000); check_all(1, "R7 wide period scaled");
    send(0, 32'h0002_0000, 0);
    // random traffic on two periods
    for (int k = 0; k < 30; k++) begin
      int pin = int'($urandom_range(0, NP - 1));
      longint per = ($urandom_range(0, 1) == 0) ? 24 : 40;
      longint pul = longint'($urandom_range(0, 32'(per)));
      if (k % 7 == 0) pul = 0;
      send(pin, per, pul);
      check_all(1, "R6 R3 R4 random traffic");
    end
    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(150000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule